// File: doc/BRIEF.md
# Clock Lane High-Speed Burst Sequencer

This block steers the line state of a differential clock lane through one high-speed clock burst, from the low-power stop state through the entry handshake, the toggling clock, and the ordered exit back to stop. All interval lengths are programmable counts of cycles of the one clock the block runs on. The counts are presented on static configuration inputs and read at the moment each interval begins. A zero count lasts one cycle, so no interval is ever skipped.

A burst begins on a request while the lane idles. The lane first leaves stop through LP-01 and then the LP-00 bridge. It parks in HS-0 and then starts toggling. Once the clock has toggled for the programmed pre-count, a grant tells the data lanes they may leave low power. When the data lanes report that their trail has ended, the clock keeps toggling for the post-count. It then parks in HS-0 for the trail count and returns to LP-11 for the exit count. A request that arrives during the exit interval is held and served as soon as that interval ends. A request at any other point of a burst is dropped.

The line state is an encoded word that an analog front end would turn into driver settings. The block has no analog, termination or receive logic.

Top module: `clk_lane_burst_seq`

## Requirements
- R1: While reset is held and after it is released with no request, line_state is 0 (LP-11 stop), data_grant is 0 and busy is 0.
- R2: A burst_req sampled high while idle drives line_state 1 (LP-01) from the next cycle for max(cfg_lpx,1) cycles, then line_state 2 (LP-00) for max(cfg_prepare,1) cycles.
- R3: After LP-00 the lane shows line_state 3 (HS-0) for max(cfg_zero,1) cycles, then line_state 4 (clock toggling).
- R4: data_grant stays 0 for the first max(cfg_pre,1) toggling cycles, then goes to 1 and stays 1 while the lane toggles and data_done is low.
- R5: data_done sampled high while data_grant is 1 drops data_grant on the next cycle, and line_state stays 4 for max(cfg_post,1) cycles counted from that cycle.
- R6: After the post interval the lane shows line_state 3 (HS-0) for max(cfg_trail,1) cycles, then line_state 0.
- R7: After the trail, line_state is 0 with busy 1 for max(cfg_exit,1) cycles, after which busy falls to 0.
- R8: Every interval programmed as zero lasts exactly one cycle.
- R9: A burst_req sampled high during the exit interval is held; line_state holds 0 until the exit interval ends and becomes 1 in the very next cycle.
- R10: A burst_req during any phase other than idle or exit has no effect: the lane returns to idle after the burst and stays there.
- R11: data_done sampled while data_grant is 0 has no effect: the toggling and the grant proceed as if it were absent.
- R12: busy is 1 from the first LP-01 cycle through the last exit cycle and 0 otherwise; line_state is 0 whenever busy is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timing clock; all intervals count its cycles |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| burst_req | input | 1 | Request for a clock burst |
| data_done | input | 1 | Data lanes have finished their trail |
| cfg_lpx | input | CNT_W | LP-01 length in cycles |
| cfg_prepare | input | CNT_W | LP-00 length in cycles |
| cfg_zero | input | CNT_W | HS-0 length before toggling |
| cfg_pre | input | CNT_W | Toggling cycles before the grant |
| cfg_post | input | CNT_W | Toggling cycles after data_done |
| cfg_trail | input | CNT_W | HS-0 length after toggling |
| cfg_exit | input | CNT_W | LP-11 length after the burst |
| line_state | output | 3 | 0 LP-11, 1 LP-01, 2 LP-00, 3 HS-0, 4 clock toggling |
| data_grant | output | 1 | Clock has run long enough for data lanes to start |
| busy | output | 1 | Burst in progress, exit interval included |

## Verification
The assertions take the configuration counts to be steady for the whole of a burst. They also take burst_req and data_done to be synchronous to clk. The ordering properties cover only the phase sequence, so any value of the counts is allowed by them. The bench changes the counts only while busy is low or before a request is issued. It drives every input on the falling edge and holds each request or done strobe for exactly one cycle, so each is sampled once by a known phase.

// File: rtl/clk_lane_pkg.sv
package clk_lane_pkg;

  typedef enum logic [2:0] {
    LS_STOP   = 3'd0,
    LS_LP01   = 3'd1,
    LS_BRIDGE = 3'd2,
    LS_HS0    = 3'd3,
    LS_HSCLK  = 3'd4
  } line_state_e;

  typedef enum logic [3:0] {
    PH_IDLE,
    PH_LP01,
    PH_PREP,
    PH_ZERO,
    PH_PRE,
    PH_RUN,
    PH_POST,
    PH_TRAIL,
    PH_EXIT
  } phase_e;

endpackage

// File: rtl/clk_lane_rst_sync.sv
module clk_lane_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_an,
  output logic rst_sync_n
);

  logic [STAGES-1:0] shift_q;

  always_ff @(posedge clk or negedge rst_an) begin
    if (!rst_an) shift_q <= '0;
    else         shift_q <= {shift_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = shift_q[STAGES-1];

endmodule

// File: rtl/clk_lane_timer.sv
module clk_lane_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_len,
  output logic             expired
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic [CNT_W-1:0] len_eff;
  logic             cnt_en;

  // A programmed zero is stretched to a single cycle.
  assign len_eff = (load_len == '0) ? CNT_W'(1) : load_len;

  always_comb begin
    cnt_en = load || (cnt_q != '0);
    if (load) cnt_d = len_eff - CNT_W'(1);
    else      cnt_d = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == '0);

  // Without a reload the counter rests at zero instead of wrapping.
  assert_count_rests_at_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (expired && !load) |=> expired);

endmodule

// File: rtl/clk_lane_fsm.sv
module clk_lane_fsm
  import clk_lane_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        burst_req,
  input  logic        data_done,
  input  logic        expired,
  output phase_e      phase_nxt,
  output logic        load,
  output line_state_e line_state,
  output logic        data_grant,
  output logic        busy
);

  phase_e phase_q;
  logic   pend_q;
  logic   pend_d;

  always_comb begin
    phase_nxt = phase_q;
    pend_d    = pend_q;
    case (phase_q)
      PH_IDLE:  if (burst_req) phase_nxt = PH_LP01;
      PH_LP01:  if (expired)   phase_nxt = PH_PREP;
      PH_PREP:  if (expired)   phase_nxt = PH_ZERO;
      PH_ZERO:  if (expired)   phase_nxt = PH_PRE;
      PH_PRE:   if (expired)   phase_nxt = PH_RUN;
      PH_RUN:   if (data_done) phase_nxt = PH_POST;
      PH_POST:  if (expired)   phase_nxt = PH_TRAIL;
      PH_TRAIL: if (expired)   phase_nxt = PH_EXIT;
      PH_EXIT: begin
        if (burst_req) pend_d = 1'b1;
        if (expired) begin
          if (pend_q || burst_req) begin
            phase_nxt = PH_LP01;
            pend_d    = 1'b0;
          end else begin
            phase_nxt = PH_IDLE;
          end
        end
      end
      default:  phase_nxt = PH_IDLE;
    endcase
  end

  assign load = (phase_nxt != phase_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      pend_q  <= 1'b0;
    end else begin
      phase_q <= phase_nxt;
      pend_q  <= pend_d;
    end
  end

  always_comb begin
    case (phase_q)
      PH_LP01:                  line_state = LS_LP01;
      PH_PREP:                  line_state = LS_BRIDGE;
      PH_ZERO, PH_TRAIL:        line_state = LS_HS0;
      PH_PRE, PH_RUN, PH_POST:  line_state = LS_HSCLK;
      default:                  line_state = LS_STOP;
    endcase
  end

  assign data_grant = (phase_q == PH_RUN);
  assign busy       = (phase_q != PH_IDLE);

  assert_grant_only_toggling_R4: assert property (@(posedge clk) disable iff (!rst_n)
    data_grant |-> (line_state == LS_HSCLK));

  assert_idle_leaves_to_lp01_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy) |=> (line_state inside {LS_STOP, LS_LP01}));

  assert_lp01_then_bridge_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (line_state == LS_LP01) |=> (line_state inside {LS_LP01, LS_BRIDGE}));

  assert_bridge_then_hs0_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (line_state == LS_BRIDGE) |=> (line_state inside {LS_BRIDGE, LS_HS0}));

  assert_toggle_ends_in_hs0_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (line_state == LS_HSCLK) |=> (line_state inside {LS_HSCLK, LS_HS0}));

  assert_grant_drops_on_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (data_grant && data_done) |=> (!data_grant && (line_state == LS_HSCLK)));

  assert_exit_held_stop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((phase_q == PH_EXIT) && !expired) |=> ((line_state == LS_STOP) && busy));

  assert_idle_is_stop_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy) |-> (line_state == LS_STOP));

endmodule

// File: rtl/clk_lane_burst_seq.sv
module clk_lane_burst_seq
  import clk_lane_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             burst_req,
  input  logic             data_done,
  input  logic [CNT_W-1:0] cfg_lpx,
  input  logic [CNT_W-1:0] cfg_prepare,
  input  logic [CNT_W-1:0] cfg_zero,
  input  logic [CNT_W-1:0] cfg_pre,
  input  logic [CNT_W-1:0] cfg_post,
  input  logic [CNT_W-1:0] cfg_trail,
  input  logic [CNT_W-1:0] cfg_exit,
  output logic [2:0]       line_state,
  output logic             data_grant,
  output logic             busy
);

  localparam int SYNC_STAGES = 2;

  logic             rst_int_n;
  logic             load;
  logic             expired;
  logic [CNT_W-1:0] load_len;
  phase_e           phase_nxt;
  line_state_e      ls;

  clk_lane_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_an     (rst_n),
    .rst_sync_n (rst_int_n)
  );

  // Length of the interval that starts on the coming edge.
  always_comb begin
    case (phase_nxt)
      PH_LP01:  load_len = cfg_lpx;
      PH_PREP:  load_len = cfg_prepare;
      PH_ZERO:  load_len = cfg_zero;
      PH_PRE:   load_len = cfg_pre;
      PH_POST:  load_len = cfg_post;
      PH_TRAIL: load_len = cfg_trail;
      PH_EXIT:  load_len = cfg_exit;
      default:  load_len = '0;
    endcase
  end

  clk_lane_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .load     (load),
    .load_len (load_len),
    .expired  (expired)
  );

  clk_lane_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .burst_req  (burst_req),
    .data_done  (data_done),
    .expired    (expired),
    .phase_nxt  (phase_nxt),
    .load       (load),
    .line_state (ls),
    .data_grant (data_grant),
    .busy       (busy)
  );

  assign line_state = ls;

endmodule

// File: tb/clk_lane_burst_seq_test.sv
module clk_lane_burst_seq_test;

  localparam int CNT_W = 8;
  localparam logic [2:0] C_STOP = 3'd0, C_LP01 = 3'd1, C_BRIDGE = 3'd2,
                         C_HS0 = 3'd3, C_CLK = 3'd4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic burst_req = 1'b0;
  logic data_done = 1'b0;
  logic [CNT_W-1:0] cfg_lpx = '0, cfg_prepare = '0, cfg_zero = '0, cfg_pre = '0;
  logic [CNT_W-1:0] cfg_post = '0, cfg_trail = '0, cfg_exit = '0;
  logic [2:0] line_state;
  logic data_grant, busy;

  int checks = 0;
  int fails = 0;

  always #2 clk = ~clk;

  clk_lane_burst_seq #(.CNT_W(CNT_W)) uut (
    .clk(clk), .rst_n(rst_n), .burst_req(burst_req), .data_done(data_done),
    .cfg_lpx(cfg_lpx), .cfg_prepare(cfg_prepare), .cfg_zero(cfg_zero),
    .cfg_pre(cfg_pre), .cfg_post(cfg_post), .cfg_trail(cfg_trail),
    .cfg_exit(cfg_exit), .line_state(line_state), .data_grant(data_grant),
    .busy(busy)
  );

  function automatic int eff(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  // Checks n cycles of one segment; poke 1 pulses burst_req, 2 pulses data_done in its first cycle.
  task automatic seg(input logic [2:0] st, input logic g, input logic b,
                     input int n, input int poke, input string tag);
    bit bad = 1'b0;
    for (int i = 0; i < n; i++) begin
      if (!bad && (line_state !== st || data_grant !== g || busy !== b)) begin
        bad = 1'b1;
        $display("FAIL %s cycle %0d: line=%0d grant=%0b busy=%0b expected line=%0d grant=%0b busy=%0b",
                 tag, i, line_state, data_grant, busy, st, g, b);
      end
      if (i == 0 && poke == 1) burst_req = 1'b1;
      if (i == 0 && poke == 2) data_done = 1'b1;
      @(negedge clk);
      burst_req = 1'b0;
      data_done = 1'b0;
    end
    checks++;
    if (bad) fails++;
  endtask

  task automatic run_burst(input int l, input int p, input int z, input int pr,
                           input int po, input int tr, input int ex, input int runc,
                           input bit skip_req, input int pre_poke, input int run_poke,
                           input int exit_poke, input string tg);
    if (!skip_req) begin
      cfg_lpx = CNT_W'(l); cfg_prepare = CNT_W'(p); cfg_zero = CNT_W'(z);
      cfg_pre = CNT_W'(pr); cfg_post = CNT_W'(po); cfg_trail = CNT_W'(tr);
      cfg_exit = CNT_W'(ex);
      burst_req = 1'b1;
      @(negedge clk);
      burst_req = 1'b0;
    end
    seg(C_LP01,   1'b0, 1'b1, eff(l),  0,         {tg, " R2/R12 lp-01"});
    seg(C_BRIDGE, 1'b0, 1'b1, eff(p),  0,         {tg, " R2 lp-00"});
    seg(C_HS0,    1'b0, 1'b1, eff(z),  0,         {tg, " R3 hs-0 zero"});
    seg(C_CLK,    1'b0, 1'b1, eff(pr), pre_poke,  {tg, " R3/R4 pre toggling"});
    seg(C_CLK,    1'b1, 1'b1, runc,    run_poke,  {tg, " R4 granted"});
    data_done = 1'b1;
    @(negedge clk);
    data_done = 1'b0;
    seg(C_CLK,    1'b0, 1'b1, eff(po), 0,         {tg, " R5 post toggling"});
    seg(C_HS0,    1'b0, 1'b1, eff(tr), 0,         {tg, " R6 trail"});
    seg(C_STOP,   1'b0, 1'b1, eff(ex), exit_poke, {tg, " R7 exit"});
    if (exit_poke == 0)
      seg(C_STOP, 1'b0, 1'b0, 4, 0, {tg, " R7/R12 idle after exit"});
  endtask

  task automatic t_reset;
    checks++;
    if (line_state !== C_STOP || data_grant !== 1'b0 || busy !== 1'b0) begin
      fails++;
      $display("FAIL R1 during reset: line=%0d grant=%0b busy=%0b expected line=0 grant=0 busy=0",
               line_state, data_grant, busy);
    end
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    seg(C_STOP, 1'b0, 1'b0, 3, 0, "R1 after reset release");
  endtask

  task automatic t_basic;
    run_burst(3, 4, 6, 8, 10, 5, 7, 4, 1'b0, 0, 0, 0, "basic");
    run_burst(2, 3, 2, 9, 53, 4, 12, 2, 1'b0, 0, 0, 0, "basic-2");
  endtask

  task automatic t_zero_counts;
    run_burst(0, 0, 0, 0, 0, 0, 0, 1, 1'b0, 0, 0, 0, "R8 zero counts");
    run_burst(1, 0, 1, 0, 1, 0, 1, 1, 1'b0, 0, 0, 0, "R8 mixed one/zero");
  endtask

  task automatic t_pending;
    run_burst(2, 2, 3, 4, 5, 3, 6, 2, 1'b0, 0, 0, 1, "R9 request in exit");
    run_burst(2, 2, 3, 4, 5, 3, 6, 2, 1'b1, 0, 0, 0, "R9 pending burst");
    run_burst(2, 2, 2, 2, 2, 2, 1, 1, 1'b0, 0, 0, 1, "R9 request on last exit cycle");
    run_burst(2, 2, 2, 2, 2, 2, 1, 1, 1'b1, 0, 0, 0, "R9 second pending burst");
  endtask

  task automatic t_ignore_req;
    run_burst(2, 2, 2, 3, 4, 2, 3, 3, 1'b0, 0, 1, 0, "R10 request while granted");
  endtask

  task automatic t_ignore_done;
    run_burst(2, 2, 2, 5, 4, 2, 3, 2, 1'b0, 2, 0, 0, "R11 done before grant");
  endtask

  task automatic t_long;
    run_burst(5, 9, 20, 200, 255, 60, 100, 7, 1'b0, 0, 0, 0, "long counts");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_basic();
    t_zero_counts();
    t_pending();
    t_ignore_req();
    t_ignore_done();
    t_long();
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    #(4 * 150000);
    checks++;
    fails++;
    $display("FAIL watchdog expired: run did not complete, expected completion");
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

endmodule